// File: doc/BRIEF.md
# Flash Page-Erase and Word-Program Sequencer

This block sequences page erase and word programming of a small on-chip flash array that it holds internally as behavioural storage. Software drives it over a byte-wide register bus with five registers: a control/status register, a write-data register, a high and a low word-address register, and a write-timing register. One command can erase a page, program one 4-byte word, or erase the page and then program the word.

A program command opens a word. Software then loads the word's four bytes one at a time into the data register. A word-busy flag paces those loads: it is high while a byte (or a chained erase) is being committed, and low when the next byte may be loaded. Programming can only clear bits, so each stored byte becomes the old value ANDed with the data byte. Erase sets every byte of the page to 0xFF. Every erase or program step runs for a number of clock cycles equal to the timing value times a per-operation multiplier. A separate read port returns stored bytes and produces a flash read-enable that is either pulsed on request or held on continuously.

The sequencer has four states: ST_IDLE, ST_ERASE, ST_WAIT_DATA and ST_PROG. The named transitions are:
- ST_IDLE→ST_ERASE: a command with the erase bit set.
- ST_IDLE→ST_WAIT_DATA: a command with only the write bit set.
- ST_ERASE→ST_WAIT_DATA: the erase step ends and a write is chained.
- ST_ERASE→ST_IDLE: the erase step ends and no write is chained.
- ST_WAIT_DATA→ST_PROG: the data register is written.
- ST_PROG→ST_WAIT_DATA: a byte step ends and bytes remain.
- ST_PROG→ST_IDLE: the fourth byte step ends.

Top module: `flashctl_top`

## Requirements
- R1: After reset, the registers read as follows: control 0x00, data 0x00, high address 0x00, low address 0x00, timing 0x2A. Every array byte reads 0xFF. Register selects are 0 control, 1 data, 2 high address, 3 low address, 4 timing.
- R2: The control register fields are: bit 7 busy, bit 6 word-busy, bit 4 continuous-read mode (read/write), bit 1 write, bit 0 erase. Bits 1 and 0 and the unused bits 5, 3 and 2 always read 0. The high address register reads bit 7 as 0. The timing register reads bits 7:6 as 0.
- R3: Writing control with bit 0 set and bit 1 clear erases one page. Busy and word-busy are both 1 for exactly ERASE_MULT×T cycles after the write edge, where T is the timing value. Then every byte of the selected page reads 0xFF and the other pages are unchanged. The page is taken from high-address bits [PAGE_IDX_BITS:1].
- R4: Writing control with bit 1 set and bit 0 clear opens a word. Busy is 1 and word-busy is 0 until a data byte is written. Each data write holds word-busy at 1 for PROG_MULT×T cycles and then ANDs the byte into the next byte of the word, in order 0 to 3. After the fourth byte, busy returns to 0.
- R5: Writing control with bits 1 and 0 both set erases the page first, with word-busy high for ERASE_MULT×T cycles. It then programs the word as in R4.
- R6: A control write with bit 1 or bit 0 set while busy is 1 starts nothing and does not lengthen the running operation.
- R7: A data-register write while word-busy is 1 is ignored. The register keeps its value and no extra byte is programmed.
- R8: rd_data shows the array byte at rd_addr. The byte address is {page, word, byte}, with the word taken from the low address bits [WORD_IDX_BITS-1:0]. High-address bit 0 does not select storage. rd_en is 1 whenever rd_req is 1 or continuous-read mode is 1, and 0 otherwise.
- R9: The page and word are captured when a command starts. Address register writes during an operation do not move it.
- R10: A timing value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 3 | Register select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_sel |
| rd_req | input | 1 | Array read request |
| rd_addr | input | PAGE_IDX_BITS+WORD_IDX_BITS+2 | Array byte address |
| rd_data | output | 8 | Array byte at rd_addr |
| rd_en | output | 1 | Flash read enable |

## Verification
The bench builds the block with its defaults: PAGE_IDX_BITS=2, WORD_IDX_BITS=3, ERASE_MULT=2 and PROG_MULT=1. That gives a 128-byte array of four 32-byte pages, small enough to check a whole-page erase and an untouched neighbour page byte by byte. The narrow page index lets a high address with bit 0 set alias onto the same page, so that case can be tested. At run time the bench writes a timing value of 2, which makes erase steps 4 cycles and byte steps 2 cycles, and later writes 0 to reach the R10 floor. With such short steps, every busy edge can be checked at its exact cycle.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ERASE     = 2'd1,
        ST_WAIT_DATA = 2'd2,
        ST_PROG      = 2'd3
    } fc_state_e;

    localparam logic [2:0] SEL_CTRL    = 3'd0;
    localparam logic [2:0] SEL_DATA    = 3'd1;
    localparam logic [2:0] SEL_ADDR_HI = 3'd2;
    localparam logic [2:0] SEL_ADDR_LO = 3'd3;
    localparam logic [2:0] SEL_TIMING  = 3'd4;

    localparam int          WORD_BYTES   = 4;
    localparam int          TIMING_W     = 6;
    localparam logic [5:0]  TIMING_RESET = 6'h2A;

    localparam int CTRL_BUSY   = 7;
    localparam int CTRL_WBUSY  = 6;
    localparam int CTRL_CONTRD = 4;
    localparam int CTRL_WRITE  = 1;
    localparam int CTRL_ERASE  = 0;

endpackage

// File: rtl/flashctl_step_timer.sv
module flashctl_step_timer #(
    parameter int CNT_W      = 8,
    parameter int ERASE_MULT = 2,
    parameter int PROG_MULT  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_erase,
    input  logic [5:0] fwt,
    output logic       done
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [5:0]       fwt_eff;
    logic [CNT_W-1:0] period;

    always_comb begin
        fwt_eff = (fwt == 6'd0) ? 6'd1 : fwt;
        period  = CNT_W'(fwt_eff) *
                  (start_erase ? CNT_W'(ERASE_MULT) : CNT_W'(PROG_MULT));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= period - CNT_W'(1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = run_q && (cnt_q == '0);

endmodule

// File: rtl/flashctl_seq.sv
module flashctl_seq
    import flashctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_go,
    input  logic       cmd_write,
    input  logic       cmd_erase,
    input  logic       data_wr,
    input  logic       step_done,
    output fc_state_e  state,
    output logic       timer_start,
    output logic       timer_erase,
    output logic       erase_fire,
    output logic       prog_fire,
    output logic [1:0] byte_idx,
    output logic       busy,
    output logic       wbusy
);
    fc_state_e  state_q, state_d;
    logic       chain_q;
    logic [1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (cmd_go) state_d = cmd_erase ? ST_ERASE : ST_WAIT_DATA;
            ST_ERASE:
                if (step_done) state_d = chain_q ? ST_WAIT_DATA : ST_IDLE;
            ST_WAIT_DATA:
                if (data_wr) state_d = ST_PROG;
            ST_PROG:
                if (step_done)
                    state_d = (idx_q == 2'(WORD_BYTES - 1)) ? ST_IDLE : ST_WAIT_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chain_q <= 1'b0;
            idx_q   <= 2'd0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_go) begin
                chain_q <= cmd_write;
                idx_q   <= 2'd0;
            end else if (state_q == ST_PROG && step_done) begin
                idx_q <= idx_q + 2'd1;
            end
        end
    end

    always_comb begin
        state       = state_q;
        byte_idx    = idx_q;
        busy        = (state_q != ST_IDLE);
        wbusy       = (state_q == ST_ERASE) || (state_q == ST_PROG);
        timer_erase = (state_q == ST_IDLE);
        timer_start = ((state_q == ST_IDLE) && cmd_go && cmd_erase) ||
                      ((state_q == ST_WAIT_DATA) && data_wr);
        erase_fire  = (state_q == ST_ERASE) && step_done;
        prog_fire   = (state_q == ST_PROG) && step_done;
    end

endmodule

// File: rtl/flashctl_array.sv
module flashctl_array #(
    parameter int PAGE_IDX_BITS = 2,
    parameter int WORD_IDX_BITS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     erase_en,
    input  logic [PAGE_IDX_BITS-1:0] erase_page,
    input  logic                     prog_en,
    input  logic [PAGE_IDX_BITS+WORD_IDX_BITS+1:0] prog_addr,
    input  logic [7:0]               prog_data,
    input  logic [PAGE_IDX_BITS+WORD_IDX_BITS+1:0] rd_addr,
    output logic [7:0]               rd_data
);
    localparam int OFS_W     = WORD_IDX_BITS + 2;
    localparam int BYTE_AW   = PAGE_IDX_BITS + OFS_W;
    localparam int NUM_BYTES = 1 << BYTE_AW;

    logic [7:0] mem [NUM_BYTES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (!rst_n)
                mem[i] <= 8'hFF;
            else if (erase_en && ((BYTE_AW'(i) >> OFS_W) == BYTE_AW'(erase_page)))
                mem[i] <= 8'hFF;
            else if (prog_en && (prog_addr == BYTE_AW'(i)))
                mem[i] <= mem[i] & prog_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
    import flashctl_pkg::*;
#(
    parameter int PAGE_IDX_BITS = 2,
    parameter int WORD_IDX_BITS = 3,
    parameter int ERASE_MULT    = 2,
    parameter int PROG_MULT     = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_sel,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rd_req,
    input  logic [PAGE_IDX_BITS+WORD_IDX_BITS+1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       rd_en
);
    localparam int BYTE_AW  = PAGE_IDX_BITS + WORD_IDX_BITS + 2;
    localparam int MULT_MAX = (ERASE_MULT > PROG_MULT) ? ERASE_MULT : PROG_MULT;
    localparam int CNT_W    = TIMING_W + $clog2(MULT_MAX + 1);

    logic                     contrd_q;
    logic [7:0]               data_q;
    logic [6:0]               addr_hi_q;
    logic [7:0]               addr_lo_q;
    logic [5:0]               fwt_q;
    logic [PAGE_IDX_BITS-1:0] tgt_page_q;
    logic [WORD_IDX_BITS-1:0] tgt_word_q;

    fc_state_e  seq_state;
    logic       seq_busy, seq_wbusy, t_start, t_erase, t_done;
    logic       erase_fire, prog_fire;
    logic [1:0] byte_idx;
    logic       ctrl_wr, cmd_go, data_wr;

    assign ctrl_wr = bus_we && (bus_sel == SEL_CTRL);
    assign cmd_go  = ctrl_wr && (bus_wdata[CTRL_WRITE] || bus_wdata[CTRL_ERASE]);
    assign data_wr = bus_we && (bus_sel == SEL_DATA) && !seq_wbusy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            contrd_q   <= 1'b0;
            data_q     <= 8'h00;
            addr_hi_q  <= 7'h00;
            addr_lo_q  <= 8'h00;
            fwt_q      <= TIMING_RESET;
            tgt_page_q <= '0;
            tgt_word_q <= '0;
        end else begin
            if (ctrl_wr) contrd_q <= bus_wdata[CTRL_CONTRD];
            if (data_wr) data_q <= bus_wdata;
            if (bus_we && bus_sel == SEL_ADDR_HI) addr_hi_q <= bus_wdata[6:0];
            if (bus_we && bus_sel == SEL_ADDR_LO) addr_lo_q <= bus_wdata;
            if (bus_we && bus_sel == SEL_TIMING)  fwt_q     <= bus_wdata[5:0];
            if (cmd_go && !seq_busy) begin
                tgt_page_q <= addr_hi_q[PAGE_IDX_BITS:1];
                tgt_word_q <= addr_lo_q[WORD_IDX_BITS-1:0];
            end
        end
    end

    always_comb begin
        unique case (bus_sel)
            SEL_CTRL:    bus_rdata = {seq_busy, seq_wbusy, 1'b0, contrd_q, 4'b0000};
            SEL_DATA:    bus_rdata = data_q;
            SEL_ADDR_HI: bus_rdata = {1'b0, addr_hi_q};
            SEL_ADDR_LO: bus_rdata = addr_lo_q;
            SEL_TIMING:  bus_rdata = {2'b00, fwt_q};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign rd_en = rd_req || contrd_q;

    flashctl_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (cmd_go),
        .cmd_write  (bus_wdata[CTRL_WRITE]),
        .cmd_erase  (bus_wdata[CTRL_ERASE]),
        .data_wr    (data_wr),
        .step_done  (t_done),
        .state      (seq_state),
        .timer_start(t_start),
        .timer_erase(t_erase),
        .erase_fire (erase_fire),
        .prog_fire  (prog_fire),
        .byte_idx   (byte_idx),
        .busy       (seq_busy),
        .wbusy      (seq_wbusy)
    );

    flashctl_step_timer #(
        .CNT_W     (CNT_W),
        .ERASE_MULT(ERASE_MULT),
        .PROG_MULT (PROG_MULT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (t_start),
        .start_erase(t_erase),
        .fwt        (fwt_q),
        .done       (t_done)
    );

    flashctl_array #(
        .PAGE_IDX_BITS(PAGE_IDX_BITS),
        .WORD_IDX_BITS(WORD_IDX_BITS)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_en  (erase_fire),
        .erase_page(tgt_page_q),
        .prog_en   (prog_fire),
        .prog_addr ({tgt_page_q, tgt_word_q, byte_idx}),
        .prog_data (data_q),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/flashctl_chk.sv
module flashctl_chk
    import flashctl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_sel,
    input logic       bus_we,
    input logic [1:0] cmd_bits,
    input logic       busy,
    input logic       wbusy,
    input fc_state_e  state,
    input logic [7:0] data_q
);
    // R4: word-busy only ever inside an operation
    a_r4_wbusy_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wbusy |-> busy);

    // R3: an operation begins only on a control write carrying a command bit
    a_r3_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we && bus_sel == SEL_CTRL && cmd_bits != 2'b00));

    // R6: erase is entered only from idle, never restarted mid-operation
    a_r6_erase_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_ERASE) |-> $past(state == ST_IDLE));

    // R7: a data write during word-busy leaves the data register unchanged
    a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sel == SEL_DATA && wbusy) |=> $stable(data_q));

    // R4: a byte step starts only from the data-wait state
    a_r4_prog_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_PROG) |-> $past(state == ST_WAIT_DATA));

endmodule

bind flashctl_top flashctl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .cmd_bits(bus_wdata[1:0]),
    .busy    (seq_busy),
    .wbusy   (seq_wbusy),
    .state   (seq_state),
    .data_q  (data_q)
);

// File: tb/test_flashctl_top.sv
module test_flashctl_top;
    localparam int CLK_PERIOD = 10;
    localparam int PIB = 2;
    localparam int WIB = 3;
    localparam int EMUL = 2;
    localparam int PMUL = 1;
    localparam int AW = PIB + WIB + 2;
    localparam int FWT_RUN = 2;
    localparam int EP = EMUL * FWT_RUN;
    localparam int PP = PMUL * FWT_RUN;

    // {addr_hi, addr_lo, erase_first, data bytes 0..3, expected bytes 0..3}
    localparam logic [80:0] VEC [6] = '{
        {8'h00, 8'h00, 1'b0, 32'h12345678, 32'h12345678},
        {8'h00, 8'h00, 1'b0, 32'hF00FFF00, 32'h10045600},
        {8'h00, 8'h00, 1'b1, 32'hAABBCCDD, 32'hAABBCCDD},
        {8'h02, 8'h05, 1'b0, 32'h01020304, 32'h01020304},
        {8'h03, 8'h05, 1'b0, 32'hFEFFFFFF, 32'h00020304},
        {8'h06, 8'h07, 1'b1, 32'h5AA53CC3, 32'h5AA53CC3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bus_sel = 3'd0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          rd_en;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flashctl_top #(
        .PAGE_IDX_BITS(PIB), .WORD_IDX_BITS(WIB),
        .ERASE_MULT(EMUL), .PROG_MULT(PMUL)
    ) i_flashctl_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_en(rd_en)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_chk(input string tag, input logic [2:0] sel, input logic [7:0] exp);
        bus_sel = sel;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic mem_chk(input string tag, input int a, input logic [7:0] exp);
        rd_addr = AW'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic busy_chk(input string tag, input logic b, input logic w);
        bus_sel = 3'd0;
        #1;
        chk(tag, bus_rdata & 8'hC0, {b, w, 6'b0});
    endtask

    function automatic int baddr(input int page, input int word, input int k);
        return page * 32 + word * 4 + k;
    endfunction

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        reg_chk("R1 ctrl", 3'd0, 8'h00);
        reg_chk("R1 data", 3'd1, 8'h00);
        reg_chk("R1 addr_hi", 3'd2, 8'h00);
        reg_chk("R1 addr_lo", 3'd3, 8'h00);
        reg_chk("R1 timing", 3'd4, 8'h2A);
        mem_chk("R1 array", 0, 8'hFF);

        // R2 register field widths and zero reads
        bus_write(3'd0, 8'h3C);
        reg_chk("R2 ctrl mode bit only", 3'd0, 8'h10);
        bus_write(3'd2, 8'hFF);
        reg_chk("R2 addr_hi bit7", 3'd2, 8'h7F);
        bus_write(3'd4, 8'hFF);
        reg_chk("R2 timing bits7:6", 3'd4, 8'h3F);

        // R8 read enable
        rd_req = 1'b0;
        #1 chk("R8 rd_en continuous", {7'b0, rd_en}, 8'h01);
        bus_write(3'd0, 8'h00);
        #1 chk("R8 rd_en idle", {7'b0, rd_en}, 8'h00);
        rd_req = 1'b1;
        #1 chk("R8 rd_en on request", {7'b0, rd_en}, 8'h01);
        rd_req = 1'b0;

        bus_write(3'd4, 8'(FWT_RUN));

        // R4/R5 table walk
        for (int v = 0; v < 6; v++) begin
            logic [7:0]  hi, lo;
            logic        ers;
            logic [31:0] dat, exp;
            int          pg, wd;
            {hi, lo, ers, dat, exp} = VEC[v];
            pg = int'(hi[2:1]);
            wd = int'(lo[2:0]);
            bus_write(3'd2, hi);
            bus_write(3'd3, lo);
            bus_write(3'd0, ers ? 8'h03 : 8'h02);
            if (ers) begin
                busy_chk("R5 erase phase start", 1'b1, 1'b1);
                repeat (EP - 1) @(negedge clk);
                busy_chk("R5 erase phase end-1", 1'b1, 1'b1);
                @(negedge clk);
                busy_chk("R5 erase phase done", 1'b1, 1'b0);
            end else begin
                busy_chk("R4 wait data", 1'b1, 1'b0);
            end
            for (int k = 0; k < 4; k++) begin
                bus_write(3'd1, dat[31 - 8 * k -: 8]);
                busy_chk("R4 byte step busy", 1'b1, 1'b1);
                repeat (PP - 1) @(negedge clk);
                @(negedge clk);
                busy_chk("R4 byte step end", k != 3, 1'b0);
            end
            for (int k = 0; k < 4; k++)
                mem_chk("R4 R5 stored byte", baddr(pg, wd, k), exp[31 - 8 * k -: 8]);
        end

        // R3/R6 erase-only with a rejected command mid-way
        bus_write(3'd2, 8'h00);
        bus_write(3'd0, 8'h01);
        busy_chk("R3 erase busy", 1'b1, 1'b1);
        bus_write(3'd0, 8'h02);
        @(negedge clk);
        busy_chk("R3 erase last cycle", 1'b1, 1'b1);
        @(negedge clk);
        busy_chk("R6 second command ignored", 1'b0, 1'b0);
        mem_chk("R3 page0 first", 0, 8'hFF);
        mem_chk("R3 page0 last", 31, 8'hFF);
        mem_chk("R3 page1 untouched", baddr(1, 5, 0), 8'h00);
        mem_chk("R3 page3 untouched", baddr(3, 7, 0), 8'h5A);

        // R7/R9 blocked data write and address change during operation
        bus_write(3'd2, 8'h04);
        bus_write(3'd3, 8'h01);
        bus_write(3'd0, 8'h02);
        bus_write(3'd3, 8'h02);
        bus_write(3'd1, 8'h3C);
        bus_write(3'd1, 8'h00);
        reg_chk("R7 data reg unchanged", 3'd1, 8'h3C);
        @(negedge clk);
        busy_chk("R7 byte0 done", 1'b1, 1'b0);
        for (int k = 1; k < 4; k++) begin
            bus_write(3'd1, 8'(8'h11 * k));
            repeat (PP) @(negedge clk);
        end
        busy_chk("R4 word done", 1'b0, 1'b0);
        mem_chk("R7 byte0", baddr(2, 1, 0), 8'h3C);
        mem_chk("R7 byte1 not shifted", baddr(2, 1, 1), 8'h11);
        mem_chk("R9 byte2", baddr(2, 1, 2), 8'h22);
        mem_chk("R9 byte3", baddr(2, 1, 3), 8'h33);
        mem_chk("R9 new address untouched", baddr(2, 2, 1), 8'hFF);

        // R10 timing 0 acts as 1
        bus_write(3'd4, 8'h00);
        reg_chk("R10 timing reads 0", 3'd4, 8'h00);
        bus_write(3'd0, 8'h01);
        @(negedge clk);
        busy_chk("R10 erase still busy", 1'b1, 1'b1);
        @(negedge clk);
        busy_chk("R10 erase done after 2", 1'b0, 1'b0);
        mem_chk("R10 page2 erased", baddr(2, 1, 0), 8'hFF);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule